// File: doc/BRIEF.md
# Fetch Next-PC Predictor

This block chooses, every cycle, the address a single-issue RV32 fetch unit reads next. It looks at the current fetch address and the instruction word returned for it, and picks among four sources: a direct-mapped branch target buffer with a 2-bit saturating direction counter per entry, a fast path that decodes JAL in fetch and adds its immediate to the PC, a small call/return stack that supplies function return targets, and sequential fall-through to PC+4. The choice is combinational, so a correctly predicted taken branch leaves no bubble.

The decode-stage branch resolver drives an update port. Every valid update trains the buffer entry for the resolved PC. An update flagged as a mispredict also redirects fetch and overrides every prediction in the same cycle. Next to the address, the block outputs the chosen source, the taken guess, the lookup hit and the counter value, so later stages can judge the prediction.

Top module: `npc_predictor`

## Requirements
- R1: After reset every buffer entry is invalid. With no training, a non-jump instruction predicts PC+4 with btb_hit=0, pred_ctr=0, pred_taken=0 and pred_src=0 (sequential).
- R2: A buffer entry is used only when its stored tag equals fetch_pc[31:10] at index fetch_pc[9:2]. On a tag mismatch the block reports btb_hit=0 and pred_ctr=0 and predicts PC+4.
- R3: Direction counters are 2-bit saturating: taken adds 1 up to 3 and not-taken subtracts 1 down to 0. An update whose tag misses starts from 01 and steps once. A single opposite outcome at 3 (or 0) leaves the prediction unchanged. pred_ctr shows the counter on a hit.
- R4: On a hit with counter bit 1 set, next_pc is the cached target in the same cycle, with pred_taken=1 and pred_src=1. On a hit with the counter below 2, next_pc is PC+4 with btb_hit=1.
- R5: A JAL (opcode 1101111) in fetch gives next_pc = fetch_pc + its J-type immediate, with pred_taken=1 and pred_src=2. This overrides a buffer hit.
- R6: When fetch_valid is high and no redirect is active, a JAL or JALR (opcode 1100111, funct3 000) with rd equal to 1 or 5 pushes fetch_pc+4 at the clock edge. A JALR with rd=0 and rs1 equal to 1 or 5 is a return. If the stack is not empty, the return predicts the top entry with pred_src=3 and pops it. If the stack is empty, the return falls to the lower-priority sources. With fetch_valid low the stack does not change.
- R7: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry, so after 9 pushes, 8 pops return the last 8 pushed values newest first and the 9th pop finds the stack empty.
- R8: A redirect is res_valid=1 with res_mispredict=1. It sets next_pc to res_target if res_taken, else res_pc+4, with pred_src=4 and pred_taken=res_taken. It wins over every other source, and the stack is neither pushed nor popped in that cycle.
- R9: Every update with res_valid=1 writes valid, tag, target and counter for res_pc, with or without a mispredict. The new values are seen by lookups from the next cycle on, and the update does not redirect fetch on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch instruction is real; gates stack push/pop |
| fetch_pc | input | 32 | Address of the instruction in fetch |
| fetch_instr | input | 32 | Instruction word at fetch_pc |
| res_valid | input | 1 | Resolver update present |
| res_pc | input | 32 | PC of the resolved control-flow instruction |
| res_taken | input | 1 | Resolved direction |
| res_target | input | 32 | Resolved taken target |
| res_mispredict | input | 1 | Resolved outcome differs from the prediction; redirect fetch |
| next_pc | output | 32 | Next fetch address |
| pred_taken | output | 1 | Chosen path is a taken transfer |
| pred_src | output | 3 | 0 seq, 1 buffer, 2 JAL, 3 return, 4 redirect |
| btb_hit | output | 1 | Buffer valid entry with matching tag |
| pred_ctr | output | 2 | Counter of the hit entry, 0 on miss |

## Verification
The hardest state to reach is a full stack that has wrapped, so that the oldest return address is gone, while redirects keep arriving that must freeze the stack under a fetched return. The stimulus builds this on purpose with nine linked jumps and then nine returns, and it fires a mispredict while a return is in fetch. Random traffic then draws PCs from a small pool that shares buffer indices across two tag values. This makes aliasing, counter saturation and retraining of an entry with a new tag happen often. A bench model of the buffer and the stack predicts every output in every cycle.

// File: rtl/npc_pkg.sv
// Shared types for the fetch next-PC predictor.
// Assumes RV32 with 32-bit aligned instruction fetch.
package npc_pkg;
    localparam int unsigned XLEN = 32;

    // Source of the chosen next PC; values are visible on pred_src.
    typedef enum logic [2:0] {
        SRC_SEQ   = 3'd0,
        SRC_BTB   = 3'd1,
        SRC_JAL   = 3'd2,
        SRC_RET   = 3'd3,
        SRC_REDIR = 3'd4
    } pred_src_e;

    localparam logic [6:0] OPC_JAL  = 7'b1101111;
    localparam logic [6:0] OPC_JALR = 7'b1100111;
endpackage

// File: rtl/npc_jdec.sv
// Fetch-stage jump decoder: spots JAL, JALR, linking calls and returns,
// and extracts the J-type immediate. Purely combinational.
// Assumes a full 32-bit (non-compressed) instruction word.
module npc_jdec
    import npc_pkg::*;
(
    input  logic [31:0] instr,
    output logic        is_jal,
    output logic        is_call,
    output logic        is_ret,
    output logic [31:0] jimm
);
    logic [4:0] rd;
    logic [4:0] rs1;
    logic       is_jalr;
    logic       rd_link;
    logic       rs1_link;

    // Field extraction and jump classification.
    always_comb begin
        rd       = instr[11:7];
        rs1      = instr[19:15];
        is_jal   = (instr[6:0] == OPC_JAL);
        is_jalr  = (instr[6:0] == OPC_JALR) && (instr[14:12] == 3'b000);
        rd_link  = (rd == 5'd1) || (rd == 5'd5);
        rs1_link = (rs1 == 5'd1) || (rs1 == 5'd5);
        is_call  = (is_jal || is_jalr) && rd_link;
        is_ret   = is_jalr && (rd == 5'd0) && rs1_link;
        jimm     = {{12{instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
    end
endmodule

// File: rtl/npc_btb.sv
// Direct-mapped target buffer with a 2-bit saturating counter per entry.
// Lookup is combinational on the word PC; update is written at the clock
// edge, so a lookup in the update cycle sees the old contents.
// Assumes word-aligned PCs (bits [1:0] are not passed in).
module npc_btb #(
    parameter int unsigned IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [29:0] rd_wpc,
    output logic        rd_hit,
    output logic [1:0]  rd_ctr,
    output logic [29:0] rd_tgt,
    input  logic        upd_en,
    input  logic [29:0] upd_wpc,
    input  logic        upd_taken,
    input  logic [29:0] upd_tgt
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned TAG_W   = 30 - IDX_W;
    localparam logic [1:0]  CTR_INIT = 2'b01;

    logic             vld_q [ENTRIES];
    logic [1:0]       ctr_q [ENTRIES];
    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [29:0]      tgt_q [ENTRIES];

    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    logic [IDX_W-1:0] u_idx;
    logic [TAG_W-1:0] u_tag;
    logic             u_match;
    logic [1:0]       u_base;
    logic [1:0]       u_next;

    // Lookup: index, tag compare, counter and target read.
    always_comb begin
        r_idx  = rd_wpc[IDX_W-1:0];
        r_tag  = rd_wpc[29:IDX_W];
        rd_hit = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
        rd_ctr = rd_hit ? ctr_q[r_idx] : 2'b00;
        rd_tgt = tgt_q[r_idx];
    end

    // Update: next counter value, starting fresh when the tag changes.
    always_comb begin
        u_idx   = upd_wpc[IDX_W-1:0];
        u_tag   = upd_wpc[29:IDX_W];
        u_match = vld_q[u_idx] && (tag_q[u_idx] == u_tag);
        u_base  = u_match ? ctr_q[u_idx] : CTR_INIT;
        if (upd_taken) begin
            u_next = (u_base == 2'b11) ? 2'b11 : u_base + 2'b01;
        end else begin
            u_next = (u_base == 2'b00) ? 2'b00 : u_base - 2'b01;
        end
    end

    // Valid bits and counters: cleared at reset, written on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i] <= 1'b0;
                ctr_q[i] <= CTR_INIT;
            end
        end else if (upd_en) begin
            vld_q[u_idx] <= 1'b1;
            ctr_q[u_idx] <= u_next;
        end
    end

    // Tag and target payload: no reset, qualified by the valid bit.
    always_ff @(posedge clk) begin
        if (upd_en) begin
            tag_q[u_idx] <= u_tag;
            tgt_q[u_idx] <= upd_tgt;
        end
    end

    // R9: an update makes the resolved PC hit from the next cycle.
    p_upd_then_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (vld_q[$past(u_idx)] && (tag_q[$past(u_idx)] == $past(u_tag))));

    // R3: a saturated taken counter stays at 3 on another taken outcome.
    p_ctr_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && u_match && (ctr_q[u_idx] == 2'b11))
        |=> (ctr_q[$past(u_idx)] == 2'b11));

    // R3: one not-taken outcome from 3 leaves the entry predicting taken.
    p_ctr_hyst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && u_match && (ctr_q[u_idx] == 2'b11))
        |=> (ctr_q[$past(u_idx)] == 2'b10));
endmodule

// File: rtl/npc_ras.sv
// Circular return address stack. A push onto a full stack overwrites the
// oldest slot. A pop on an empty stack does nothing. Push and pop never
// come together (the callers decode disjoint instructions).
// Assumes DEPTH is a power of two.
module npc_ras #(
    parameter int unsigned DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [31:0] push_val,
    input  logic        pop,
    output logic        nonempty,
    output logic [31:0] top_val
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [31:0]      stk_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] top_idx;

    // Top of stack is the slot just below the free pointer.
    always_comb begin
        top_idx  = ptr_q - PTR_W'(1);
        nonempty = (cnt_q != '0);
        top_val  = stk_q[top_idx];
    end

    // Pointer and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + PTR_W'(1);
            cnt_q <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
        end else if (pop && nonempty) begin
            ptr_q <= top_idx;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Stack storage write on push.
    always_ff @(posedge clk) begin
        if (push) begin
            stk_q[ptr_q] <= push_val;
        end
    end

    // R7: occupancy never passes the depth.
    p_ras_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R6: a pop on a non-empty stack removes exactly one entry.
    p_ras_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && nonempty) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6: a pushed value is on top in the next cycle.
    p_ras_push_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (nonempty && (top_val == $past(push_val))));
endmodule

// File: rtl/npc_predictor.sv
// Next-PC selection for a single-issue RV32 fetch stage. Merges resolver
// redirect, return stack, JAL fast path, target buffer and fall-through,
// in that priority, into one combinational next_pc.
// Assumes the resolver presents at most one update per cycle and that
// fetch_pc is word aligned.
module npc_predictor
    import npc_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned RAS_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    input  logic [31:0] fetch_instr,
    input  logic        res_valid,
    input  logic [31:0] res_pc,
    input  logic        res_taken,
    input  logic [31:0] res_target,
    input  logic        res_mispredict,
    output logic [31:0] next_pc,
    output logic        pred_taken,
    output logic [2:0]  pred_src,
    output logic        btb_hit,
    output logic [1:0]  pred_ctr
);
    logic        is_jal;
    logic        is_call;
    logic        is_ret;
    logic [31:0] jimm;
    logic        b_hit;
    logic [1:0]  b_ctr;
    logic [29:0] b_tgt;
    logic        r_nonempty;
    logic [31:0] r_top;
    logic        redirect;
    logic        fire;
    logic        ras_push;
    logic        ras_pop;
    logic        ret_use;
    logic        btb_take;
    logic [31:0] seq_pc;
    pred_src_e   src;

    npc_jdec u_jdec (
        .instr   (fetch_instr),
        .is_jal  (is_jal),
        .is_call (is_call),
        .is_ret  (is_ret),
        .jimm    (jimm)
    );

    npc_btb #(.IDX_W(IDX_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_wpc    (fetch_pc[31:2]),
        .rd_hit    (b_hit),
        .rd_ctr    (b_ctr),
        .rd_tgt    (b_tgt),
        .upd_en    (res_valid),
        .upd_wpc   (res_pc[31:2]),
        .upd_taken (res_taken),
        .upd_tgt   (res_target[31:2])
    );

    npc_ras #(.DEPTH(RAS_DEPTH)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ras_push),
        .push_val (seq_pc),
        .pop      (ras_pop),
        .nonempty (r_nonempty),
        .top_val  (r_top)
    );

    // Stack control: only real, non-flushed fetches touch the stack.
    always_comb begin
        redirect = res_valid && res_mispredict;
        fire     = fetch_valid && !redirect;
        seq_pc   = fetch_pc + 32'd4;
        ras_push = fire && is_call;
        ras_pop  = fire && is_ret;
        ret_use  = is_ret && r_nonempty;
        btb_take = b_hit && b_ctr[1];
    end

    // Priority select of the next fetch address.
    always_comb begin
        if (redirect) begin
            src        = SRC_REDIR;
            next_pc    = res_taken ? res_target : (res_pc + 32'd4);
            pred_taken = res_taken;
        end else if (ret_use) begin
            src        = SRC_RET;
            next_pc    = r_top;
            pred_taken = 1'b1;
        end else if (is_jal) begin
            src        = SRC_JAL;
            next_pc    = fetch_pc + jimm;
            pred_taken = 1'b1;
        end else if (btb_take) begin
            src        = SRC_BTB;
            next_pc    = {b_tgt, 2'b00};
            pred_taken = 1'b1;
        end else begin
            src        = SRC_SEQ;
            next_pc    = seq_pc;
            pred_taken = 1'b0;
        end
        pred_src = src;
        btb_hit  = b_hit;
        pred_ctr = b_ctr;
    end

    // R2: with no other source, fetch falls through to PC+4.
    p_seq_fallthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !ret_use && !is_jal && !btb_take) |-> (next_pc == fetch_pc + 32'd4));

    // R5: a JAL without redirect or return goes to PC plus its immediate.
    p_jal_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && (fetch_instr[6:0] == OPC_JAL))
        |-> (next_pc == fetch_pc + jimm && pred_taken));

    // R4: a taken prediction from the buffer only on a hit.
    p_btb_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_src == SRC_BTB) |-> (btb_hit && pred_ctr[1]));

    // R8: a redirect marks its source regardless of the fetched word.
    p_redirect_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |-> (pred_src == SRC_REDIR));
endmodule

// File: tb/npc_predictor_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a bench model of the buffer and stack.
module npc_predictor_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] fetch_instr = '0;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_mispredict = 1'b0;
    logic [31:0] next_pc;
    logic        pred_taken;
    logic [2:0]  pred_src;
    logic        btb_hit;
    logic [1:0]  pred_ctr;

    int tests = 0;
    int fails = 0;

    // Bench model state.
    bit          mv   [256];
    logic [21:0] mtag [256];
    logic [31:0] mtgt [256];
    logic [1:0]  mctr [256];
    logic [31:0] mstk [8];
    int          mptr = 0;
    int          mcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_predictor u_npc_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc), .fetch_instr(fetch_instr),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_mispredict(res_mispredict),
        .next_pc(next_pc), .pred_taken(pred_taken), .pred_src(pred_src),
        .btb_hit(btb_hit), .pred_ctr(pred_ctr)
    );

    function automatic logic [31:0] enc_jal(input logic [4:0] rd, input logic [20:0] imm);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [4:0] rs1);
        return {12'h000, rs1, 3'b000, rd, 7'b1100111};
    endfunction

    function automatic bit is_link(input logic [4:0] r);
        return (r == 5'd1) || (r == 5'd5);
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output with the model for the inputs now applied.
    task automatic check_model(input string tag_in);
        logic [6:0] opc;
        logic [4:0] rd;
        logic [4:0] rs1;
        bit jal, jalr, ret, hit;
        int idx;
        logic [31:0] e_pc;
        logic [2:0]  e_src;
        logic        e_tk;
        logic [1:0]  e_ctr;
        logic [31:0] jimm;
        string tag;
        opc  = fetch_instr[6:0];
        rd   = fetch_instr[11:7];
        rs1  = fetch_instr[19:15];
        jal  = (opc == 7'b1101111);
        jalr = (opc == 7'b1100111) && (fetch_instr[14:12] == 3'b000);
        ret  = jalr && (rd == 5'd0) && is_link(rs1);
        jimm = {{12{fetch_instr[31]}}, fetch_instr[19:12], fetch_instr[20],
                fetch_instr[30:21], 1'b0};
        idx  = int'(fetch_pc[9:2]);
        hit  = mv[idx] && (mtag[idx] == fetch_pc[31:10]);
        e_ctr = hit ? mctr[idx] : 2'b00;
        if (res_valid && res_mispredict) begin
            e_pc = res_taken ? res_target : res_pc + 32'd4; e_src = 3'd4; e_tk = res_taken;
        end else if (ret && mcnt > 0) begin
            e_pc = mstk[(mptr + 7) % 8]; e_src = 3'd3; e_tk = 1'b1;
        end else if (jal) begin
            e_pc = fetch_pc + jimm; e_src = 3'd2; e_tk = 1'b1;
        end else if (hit && mctr[idx][1]) begin
            e_pc = mtgt[idx]; e_src = 3'd1; e_tk = 1'b1;
        end else begin
            e_pc = fetch_pc + 32'd4; e_src = 3'd0; e_tk = 1'b0;
        end
        tag = tag_in;
        if (tag == "") begin
            case (e_src)
                3'd4: tag = "R8";
                3'd3: tag = "R6";
                3'd2: tag = "R5";
                3'd1: tag = "R4";
                default: tag = hit ? "R3" : "R2";
            endcase
        end
        check32({tag, " next_pc"}, next_pc, e_pc);
        check32({tag, " meta"}, {27'd0, pred_src, pred_taken, btb_hit, pred_ctr},
                {27'd0, e_src, e_tk, hit, e_ctr});
    endtask

    // Apply the state change of the coming clock edge to the model.
    task automatic model_edge();
        logic [4:0] rd;
        logic [4:0] rs1;
        bit jal, jalr;
        int idx;
        logic [1:0] base;
        rd   = fetch_instr[11:7];
        rs1  = fetch_instr[19:15];
        jal  = (fetch_instr[6:0] == 7'b1101111);
        jalr = (fetch_instr[6:0] == 7'b1100111) && (fetch_instr[14:12] == 3'b000);
        if (fetch_valid && !(res_valid && res_mispredict)) begin
            if ((jal || jalr) && is_link(rd)) begin
                mstk[mptr] = fetch_pc + 32'd4;
                mptr = (mptr + 1) % 8;
                if (mcnt < 8) mcnt++;
            end else if (jalr && rd == 5'd0 && is_link(rs1) && mcnt > 0) begin
                mptr = (mptr + 7) % 8;
                mcnt--;
            end
        end
        if (res_valid) begin
            idx  = int'(res_pc[9:2]);
            base = (mv[idx] && mtag[idx] == res_pc[31:10]) ? mctr[idx] : 2'b01;
            if (res_taken) mctr[idx] = (base == 2'b11) ? 2'b11 : base + 2'b01;
            else           mctr[idx] = (base == 2'b00) ? 2'b00 : base - 2'b01;
            mv[idx]   = 1'b1;
            mtag[idx] = res_pc[31:10];
            mtgt[idx] = {res_target[31:2], 2'b00};
        end
    endtask

    task automatic drive(input logic fv, input logic [31:0] pc, input logic [31:0] ins,
                         input logic rv, input logic [31:0] rpc, input logic rtk,
                         input logic [31:0] rtgt, input logic rmis);
        fetch_valid = fv; fetch_pc = pc; fetch_instr = ins;
        res_valid = rv; res_pc = rpc; res_taken = rtk; res_target = rtgt;
        res_mispredict = rmis;
    endtask

    // One cycle: settle, check against model, advance DUT and model.
    task automatic step(input string tag);
        #1;
        check_model(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic fetch_only(input logic [31:0] pc, input logic [31:0] ins);
        drive(1'b1, pc, ins, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic train(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        drive(1'b1, 32'h0000_8000, 32'h0000_0033, 1'b1, pc, tk, tgt, 1'b0);
        step("R9");
    endtask

    localparam logic [31:0] ALU  = 32'h0020_81b3;
    localparam logic [31:0] BR   = 32'h0020_8463;
    localparam logic [31:0] PA   = 32'h0000_2040;
    localparam logic [31:0] RET1 = 32'h0000_8067;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int i = 0; i < 256; i++) begin mv[i] = 1'b0; mctr[i] = 2'b01; end
        drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: untrained lookup after reset.
        fetch_only(PA, ALU);
        #1;
        check32("R1 next_pc", next_pc, PA + 32'd4);
        check32("R1 meta", {29'd0, btb_hit, pred_ctr}, 32'd0);
        step("R1");

        // R7: nine linked JALs at distinct PCs, then nine returns.
        for (int k = 0; k < 9; k++) begin
            fetch_only(32'h0000_0100 + 32'(8 * k), enc_jal(5'd1, 21'd64));
            step("R6");
        end
        for (int k = 8; k >= 1; k--) begin
            fetch_only(32'h0000_9000, RET1);
            #1;
            check32("R7 pop order", next_pc, 32'h0000_0104 + 32'(8 * k));
            step("R7");
        end
        fetch_only(32'h0000_9000, RET1);
        #1;
        check32("R7 empty after wrap", next_pc, 32'h0000_9004);
        step("R7");

        // R8: redirect over a fetched return; stack must stay put.
        fetch_only(32'h0000_0300, enc_jal(5'd5, 21'd32));
        step("R6");
        drive(1'b1, 32'h0000_9000, RET1, 1'b1, 32'h0000_0500, 1'b1, 32'h0000_7000, 1'b1);
        #1;
        check32("R8 redirect target", next_pc, 32'h0000_7000);
        step("R8");
        fetch_only(32'h0000_9000, RET1);
        #1;
        check32("R8 stack untouched", next_pc, 32'h0000_0304);
        step("R8");
        // R6: fetch_valid low leaves the stack alone.
        fetch_only(32'h0000_0300, enc_jal(5'd1, 21'd32));
        fetch_valid = 1'b0;
        step("R6");
        fetch_only(32'h0000_9000, RET1);
        #1;
        check32("R6 no push when invalid", next_pc, 32'h0000_9004);
        step("R6");

        // R9/R4: train PA taken; lookup in training cycle sees old data.
        drive(1'b1, PA, BR, 1'b1, PA, 1'b1, 32'h0000_3000, 1'b0);
        #1;
        check32("R9 no redirect", next_pc, PA + 32'd4);
        step("R9");
        fetch_only(PA, BR);
        #1;
        check32("R4 taken hit", next_pc, 32'h0000_3000);
        check32("R4 ctr", {30'd0, pred_ctr}, 32'd2);
        step("R4");
        // R3: one not-taken drops to 01, predicts fall-through with hit.
        train(PA, 1'b0, 32'h0000_3000);
        fetch_only(PA, BR);
        #1;
        check32("R3 weak not-taken", {next_pc[31:1], btb_hit}, {PA[31:1] + 31'd2, 1'b1});
        step("R3");
        // R3: saturate, then one not-taken keeps taken.
        repeat (4) train(PA, 1'b1, 32'h0000_3000);
        fetch_only(PA, BR);
        #1;
        check32("R3 saturated", {30'd0, pred_ctr}, 32'd3);
        step("R3");
        train(PA, 1'b0, 32'h0000_3000);
        fetch_only(PA, BR);
        #1;
        check32("R3 hysteresis", next_pc, 32'h0000_3000);
        step("R3");
        // R2: same index, different tag.
        fetch_only(PA + 32'h400, BR);
        #1;
        check32("R2 alias miss", {next_pc[31:1], btb_hit}, {PA[31:1] + 31'h202, 1'b0});
        step("R2");
        // R5: JAL overrides a taken buffer hit.
        fetch_only(PA, enc_jal(5'd0, 21'h1FFFF0));
        #1;
        check32("R5 jal over btb", next_pc, PA - 32'd16);
        step("R5");

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] pc;
            logic [31:0] ins;
            int kind;
            pc   = 32'h0000_4000 + ($urandom_range(0, 1) << 10) + ($urandom_range(0, 7) << 2);
            kind = $urandom_range(0, 9);
            case (kind)
                0, 1:    ins = ALU;
                2, 3:    ins = BR;
                4:       ins = enc_jal(($urandom_range(0, 1) != 0) ? 5'd1 : 5'd0,
                                       21'($urandom_range(0, 255) << 2) - 21'd512);
                5:       ins = enc_jalr(5'd5, 5'd7);
                6, 7:    ins = enc_jalr(5'd0, ($urandom_range(0, 1) != 0) ? 5'd1 : 5'd5);
                default: ins = enc_jalr(5'd0, 5'd6);
            endcase
            drive($urandom_range(0, 9) != 0, pc, ins,
                  $urandom_range(0, 9) < 4,
                  32'h0000_4000 + ($urandom_range(0, 1) << 10) + ($urandom_range(0, 7) << 2),
                  $urandom_range(0, 1) != 0,
                  32'($urandom_range(0, 16383)) << 2,
                  $urandom_range(0, 9) < 3);
            step("");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule